// File: doc/BRIEF.md
# Programmable Period Reload Counter

This block produces a periodic one-cycle tick, or a timeout, whose length can be set at run time to any value from 2 up to 2^N enabled clock cycles. Powers of two are not required. The counting register is one bit wider than the count range. Its extra top bit does two jobs: it is the terminal-count flag, and it is also the reload strobe. No equality or magnitude comparator is used. Instead, the register is preloaded with a value chosen so that the top bit becomes set after exactly the right number of steps.

A parameter selects the counting direction. In the incrementing variant the start value is derived from the bitwise complement of the programmed value. In the decrementing variant the start value is derived from the programmed value directly, and the borrow out of zero sets the top bit. The counter runs freely and always reloads itself. Because of this, a corrupted register value works its way back to normal operation without any outside help.

The period input carries P-1, where P is the period length. A value written to it is sampled only at reload time.

Top module: `msb_reload_counter`

## Requirements
- R1: The count register is N+1 bits wide. `count_o` shows all N+1 bits, and its top bit is the same signal as `tc_o`.
- R2: With `period_i` = P-1 and 2 ≤ P ≤ 2^N, `tc_o` rises exactly once in every P enabled clock cycles in steady operation.
- R3: With DIR = DIR_UP, the start value is the N-bit complement of `period_i` plus one, zero-extended to N+1 bits, which equals 2^N-(P-1). The register adds one on each enabled cycle.
- R4: With DIR = DIR_DOWN, the start value is `period_i` minus one, which equals P-2. The register subtracts one on each enabled cycle until it wraps to all ones. Both variants pulse on the same cycles.
- R5: `tc_o` stays high for exactly one enabled cycle per period.
- R6: A clock edge with `rst` high loads the start value and clears `tc_o`. The first pulse after reset follows P-1 enabled edges.
- R7: While `en` is low, `count_o` and `tc_o` keep their values. This holds even when `tc_o` is high.
- R8: A change of `period_i` during a period leaves the current period unchanged. The new value is used from the next reload onward.
- R9: From any register value, a pulse appears within 2^N enabled cycles. After that pulse the programmed spacing resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; loads the start value |
| en | input | 1 | Count enable |
| period_i | input | N | Period length minus one (P-1) |
| tc_o | output | 1 | Terminal-count pulse (top register bit) |
| count_o | output | N+1 | Current register value |

## Verification
Pulse spacing is measured for both directions side by side at the smallest period (2), the full range (2^N), an odd period, and periods drawn at random. A second random pass toggles the enable line, which separates counting enabled edges from counting clock edges. Directed cases do the following:
- hold the enable low both inside a period and on the pulse itself;
- rewrite the period just after a reload, showing that the old length finishes before the new one starts;
- force the register to an arbitrary value in each direction, showing the recovery distance and the return to the programmed spacing.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } count_dir_e;
endpackage

// File: rtl/rlc_start_value.sv
module rlc_start_value
    import rlc_pkg::*;
#(
    parameter int         N   = 8,
    parameter count_dir_e DIR = DIR_UP
) (
    input  logic [N-1:0] period_m1,
    output logic [N:0]   start
);
    localparam int W = N + 1;

    generate
        if (DIR == DIR_UP) begin : g_up
            // 2^N - (P-1): the top bit is reached after P-1 increments
            assign start = {1'b0, ~period_m1} + W'(1);
        end else begin : g_down
            // P-2: the borrow below zero is reached after P-1 decrements
            assign start = {1'b0, period_m1} - W'(1);
        end
    endgenerate
endmodule

// File: rtl/rlc_stepper.sv
module rlc_stepper
    import rlc_pkg::*;
#(
    parameter int         N   = 8,
    parameter count_dir_e DIR = DIR_UP
) (
    input  logic [N:0] cur,
    output logic [N:0] nxt
);
    localparam int W = N + 1;

    generate
        if (DIR == DIR_UP) begin : g_inc
            assign nxt = cur + W'(1);
        end else begin : g_dec
            assign nxt = cur - W'(1);
        end
    endgenerate
endmodule

// File: rtl/msb_reload_counter.sv
module msb_reload_counter
    import rlc_pkg::*;
#(
    parameter int         N   = 8,
    parameter count_dir_e DIR = DIR_UP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] period_i,
    output logic         tc_o,
    output logic [N:0]   count_o
);
    localparam int W = N + 1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    logic [W-1:0] cnt_q;
    state_t       st_d;
    logic [W-1:0] start_val;
    logic [W-1:0] stepped;

    rlc_start_value #(.N(N), .DIR(DIR)) u_start (
        .period_m1 (period_i),
        .start     (start_val)
    );

    rlc_stepper #(.N(N), .DIR(DIR)) u_step (
        .cur (cnt_q),
        .nxt (stepped)
    );

    // Next-state: the top bit alone selects reload, no comparator
    always_comb begin
        st_d.cnt = cnt_q;
        if (rst) begin
            st_d.cnt = start_val;
        end else if (en) begin
            st_d.cnt = cnt_q[N] ? start_val : stepped;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= st_d.cnt;
    end

    assign count_o = cnt_q;
    assign tc_o    = cnt_q[N];

    // Assertions

    // R6: reset clears the pulse for any legal period
    a_r6_reset_clears: assert property (@(posedge clk)
        rst && period_i != '0 |=> !tc_o);

    // R5: pulse lasts one enabled cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        en && tc_o && period_i != '0 |=> !tc_o);

    // R7: hold while disabled
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count_o) && $stable(tc_o));

    // R3/R4: a reload takes the start value seen at the reload edge
    a_r8_reload_value: assert property (@(posedge clk) disable iff (rst)
        en && tc_o |=> count_o == $past(start_val));

    // R9: enabled cycles since the last pulse never exceed 2^N
    logic [N+1:0] since_tc_q;
    always_ff @(posedge clk) begin
        if (rst || tc_o) since_tc_q <= '0;
        else if (en)     since_tc_q <= since_tc_q + 1'b1;
    end

    a_r9_recover: assert property (@(posedge clk) disable iff (rst)
        since_tc_q <= (N+2)'(2**N));
endmodule

// File: tb/test_msb_reload_counter.sv
module test_msb_reload_counter;
    import rlc_pkg::*;

    localparam int CLK_NS = 10;
    localparam int N      = 8;
    localparam int FULL   = 2**N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [N-1:0] per = '0;
    logic         tc_up, tc_dn;
    logic [N:0]   cnt_up, cnt_dn;

    int n_pass = 0;
    int n_fail = 0;
    bit done   = 0;

    msb_reload_counter #(.N(N), .DIR(DIR_UP)) i_msb_reload_counter (
        .clk(clk), .rst(rst), .en(en), .period_i(per),
        .tc_o(tc_up), .count_o(cnt_up)
    );

    msb_reload_counter #(.N(N), .DIR(DIR_DOWN)) i_msb_reload_counter_dn (
        .clk(clk), .rst(rst), .en(en), .period_i(per),
        .tc_o(tc_dn), .count_o(cnt_dn)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic int up_start(int m);
        return FULL - m;
    endfunction

    function automatic int dn_start(int m);
        return m - 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        if (ok) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(int m);
        per = N'(m);
        en  = 1'b1;
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    // Count enabled edges until the up-counter pulses
    task automatic gap(bit rnd, output int n);
        bit stepped;
        n = 0;
        do begin
            en = rnd ? ($urandom % 4 != 0) : 1'b1;
            stepped = en;
            tick();
            if (stepped) n++;
        end while (!(stepped && tc_up) && n < FULL + 4);
        en = 1'b1;
    endtask

    task automatic run_period(int m, bit rnd);
        int n;
        do_reset(m);
        check(!tc_up && cnt_up == (N+1)'(up_start(m)), "R3/R6 reset up", int'(cnt_up), up_start(m));
        check(!tc_dn && cnt_dn == (N+1)'(dn_start(m)), "R4/R6 reset down", int'(cnt_dn), dn_start(m));
        gap(rnd, n);
        check(n == m, "R6 first pulse", n, m);
        check(tc_dn == tc_up, "R4 directions agree", tc_dn, tc_up);
        check(cnt_up[N] == tc_up, "R1 top bit is tc", cnt_up[N], tc_up);
        for (int i = 0; i < 3; i++) begin
            gap(rnd, n);
            check(n == m + 1, "R2 spacing", n, m + 1);
            check(tc_dn == tc_up, "R4 directions agree", tc_dn, tc_up);
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
            $finish;
        end
    end

    initial begin
        int n, up1, up2, dn1, dn2;
        logic [N:0] held;
        void'($urandom(32'd4242));
        @(negedge clk);

        // R2 boundary and odd periods
        run_period(1, 0);
        run_period(FULL - 1, 0);
        run_period(6, 0);
        for (int i = 0; i < 4; i++) run_period(1 + ($urandom % (FULL - 1)), 0);
        // R2 with random enable gaps
        for (int i = 0; i < 3; i++) run_period(1 + ($urandom % 40), 1);

        // R5 pulse width
        do_reset(4);
        gap(0, n);
        tick();
        check(!tc_up && !tc_dn, "R5 pulse one cycle", tc_up, 0);

        // R7 hold mid-period and on the pulse
        do_reset(9);
        tick(); tick(); tick();
        held = cnt_up;
        en = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        check(cnt_up == held, "R7 hold count", int'(cnt_up), int'(held));
        en = 1'b1;
        gap(0, n);
        en = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        check(tc_up && tc_dn, "R7 hold pulse", tc_up, 1);
        en = 1'b1;
        tick();
        check(!tc_up, "R7 pulse released", tc_up, 0);

        // R8 period change after a reload
        do_reset(9);
        gap(0, n);
        tick();
        per = N'(19);
        gap(0, n);
        check(n == 9, "R8 old period finishes", n, 9);
        gap(0, n);
        check(n == 20, "R8 new period applies", n, 20);

        // R9 recovery from forced values
        do_reset(49);
        tick(); tick();
        force i_msb_reload_counter.cnt_q = 9'd3;
        force i_msb_reload_counter_dn.cnt_q = 9'd200;
        #1;
        release i_msb_reload_counter.cnt_q;
        release i_msb_reload_counter_dn.cnt_q;
        up1 = 0; up2 = 0; dn1 = 0; dn2 = 0;
        for (int k = 1; k <= 600; k++) begin
            tick();
            if (tc_up) begin if (up1 == 0) up1 = k; else if (up2 == 0) up2 = k; end
            if (tc_dn) begin if (dn1 == 0) dn1 = k; else if (dn2 == 0) dn2 = k; end
        end
        check(up1 == 253, "R9 up recovery", up1, 253);
        check(up2 - up1 == 50, "R9 up spacing resumes", up2 - up1, 50);
        check(dn1 == 201, "R9 down recovery", dn1, 201);
        check(dn2 - dn1 == 50, "R9 down spacing resumes", dn2 - dn1, 50);

        done = 1;
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    end
endmodule